// File: doc/BRIEF.md
# Mode-Banked Register File with Context Save Registers

This block is the architectural register file of a 32-bit core. Software always addresses registers by the same index. The block maps each index to physical storage according to the current execution mode, which it holds itself. There are eight modes: Application, Supervisor, four interrupt levels, Exception and NMI. The general registers R0–R7 are shared by all modes. The stack pointer is split into an application copy and one system copy. Each interrupt level has its own link register, and each level may shadow any of R8–R12, as chosen by a parameter mask. The program counter and the status word are single registers that every mode sees.

Every mode except Application owns a save pair: a saved status word and a saved resume address. A context-entry strobe switches the mode and fills the target's save pair in the same cycle. A return strobe restores the status word and the previous mode from that pair. This removes any need to push state onto a stack. The saved resume address of the current mode is driven on a dedicated output for the fetch unit.

Top module: `bregs_top`

## Requirements
- R1: Reset clears every register to zero, puts the block in Supervisor mode (mode_o = 1) and drives ret_addr_o and ret_err_o to 0. Mode codes are: 0 Application, 1 Supervisor, 2–5 interrupt levels 0–3, 6 Exception, 7 NMI.
- R2: Indices 0–7 select R0–R7, which are one set shared by every mode. Indices 8–12 select R8–R12, which are shared as well unless R5 shadows them.
- R3: Index 13 is the stack pointer. It selects the application stack pointer in mode 0 and one shared system stack pointer in every other mode.
- R4: Index 14 is the link register. It selects a private copy for each interrupt level in modes 2–5, and one common copy in all other modes.
- R5: Parameter SHADOW_MASK holds 5 bits per interrupt level, with level L at bits [5L+4:5L] and bit k standing for R(8+k). In an interrupt mode, a set bit redirects that index to the level's private copy. The default is level0 none, level1 R8–R9, level2 R8–R11, level3 R8–R12.
- R6: Index 15 (program counter) and index 16 (status word) are single registers in every mode. Indices 17–31 read zero, and writes to them have no effect.
- R7: On enter_i with target t ≠ 0, the block copies the status word into t's saved status, copies enter_addr_i into t's saved address, records the old mode and switches to t. On enter_i with target 0, it only switches to Application mode and saves nothing.
- R8: If enter_i coincides with a write to index 16, the written value is the status word that gets saved, and it is also the new status word.
- R9: On ret_i outside mode 0, the status word is restored from the current mode's saved status and the mode returns to the recorded one. The restore takes priority over a same-cycle write to index 16. ret_addr_o always shows the current mode's saved address, which is 0 in mode 0.
- R10: ret_i in mode 0 changes no register or mode, and ret_err_o goes high for exactly the following cycle.
- R11: Reads are combinational. A read of an index written in the same cycle returns the old value, and the new value is visible after the clock edge.
- R12: When enter_i and ret_i arrive together, the entry takes place and the return is dropped, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| enter_i | input | 1 | Context-entry strobe |
| enter_mode_i | input | 3 | Target mode of the entry |
| enter_addr_i | input | 32 | Resume address to save on entry |
| ret_i | input | 1 | Return strobe |
| mode_o | output | 3 | Current execution mode |
| ret_addr_o | output | 32 | Saved resume address of the current mode |
| ret_err_o | output | 1 | Pulses after a return attempted in Application mode |

## Verification
The hardest state to reach is Application mode, because reset lands in Supervisor mode. The only ways in are an entry that targets mode 0 or a return to a context that was entered from mode 0. The stimulus first takes the Application path and then builds entry chains from it, including a nested Exception-then-NMI chain. This exposes the application stack pointer and the error return, and shows that each return unwinds to the recorded mode. The same-cycle cases (entry with a status write, entry with a return) are driven as single-cycle overlaps, and their effect is read back through the read ports after the edge.

// File: rtl/bregs_pkg.sv
package bregs_pkg;

    typedef enum logic [2:0] {
        MODE_APP  = 3'd0,
        MODE_SUP  = 3'd1,
        MODE_INT0 = 3'd2,
        MODE_INT1 = 3'd3,
        MODE_INT2 = 3'd4,
        MODE_INT3 = 3'd5,
        MODE_EXC  = 3'd6,
        MODE_NMI  = 3'd7
    } mode_e;

    typedef enum logic [3:0] {
        LOC_GEN,
        LOC_SHD,
        LOC_SPAPP,
        LOC_SPSYS,
        LOC_LRCOM,
        LOC_LRINT,
        LOC_PC,
        LOC_SR,
        LOC_NONE
    } loc_kind_e;

    typedef struct packed {
        loc_kind_e  kind;
        logic [4:0] sel;
    } loc_t;

    localparam int IDX_W    = 5;
    localparam int N_GEN    = 13;
    localparam int N_INT    = 4;
    localparam int N_SHD    = 5;
    localparam int SHD_BASE = 8;
    localparam int IDX_SP   = 13;
    localparam int IDX_LR   = 14;
    localparam int IDX_PC   = 15;
    localparam int IDX_SR   = 16;
    localparam int N_MODES  = 8;

endpackage

// File: rtl/bregs_map.sv
module bregs_map
    import bregs_pkg::*;
#(
    parameter logic [N_INT*N_SHD-1:0] SHADOW_MASK = 20'hFBC60
) (
    input  mode_e             mode_i,
    input  logic [IDX_W-1:0]  idx_i,
    output loc_t              loc_o
);
    logic       is_int;
    logic [1:0] lvl;
    logic [2:0] sh_k;

    always_comb begin
        is_int = (mode_i inside {MODE_INT0, MODE_INT1, MODE_INT2, MODE_INT3});
        lvl    = 2'(mode_i - MODE_INT0);
        sh_k   = 3'(idx_i - 5'(SHD_BASE));
        loc_o  = '{kind: LOC_NONE, sel: '0};
        if (int'(idx_i) < SHD_BASE) begin
            loc_o = '{kind: LOC_GEN, sel: idx_i};
        end else if (int'(idx_i) < N_GEN) begin
            if (is_int && SHADOW_MASK[int'(lvl)*N_SHD + int'(sh_k)])
                loc_o = '{kind: LOC_SHD, sel: {lvl, sh_k}};
            else
                loc_o = '{kind: LOC_GEN, sel: idx_i};
        end else if (int'(idx_i) == IDX_SP) begin
            loc_o = '{kind: (mode_i == MODE_APP) ? LOC_SPAPP : LOC_SPSYS, sel: '0};
        end else if (int'(idx_i) == IDX_LR) begin
            if (is_int) loc_o = '{kind: LOC_LRINT, sel: {3'd0, lvl}};
            else        loc_o = '{kind: LOC_LRCOM, sel: '0};
        end else if (int'(idx_i) == IDX_PC) begin
            loc_o = '{kind: LOC_PC, sel: '0};
        end else if (int'(idx_i) == IDX_SR) begin
            loc_o = '{kind: LOC_SR, sel: '0};
        end
    end

endmodule

// File: rtl/bregs_ctx.sv
module bregs_ctx
    import bregs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter_i,
    input  mode_e         enter_mode_i,
    input  logic [DW-1:0] enter_addr_i,
    input  logic          ret_i,
    input  logic [DW-1:0] sr_save_i,
    output mode_e         mode_o,
    output logic [DW-1:0] ret_status_o,
    output logic [DW-1:0] ret_addr_o,
    output logic          restore_o,
    output logic          ret_err_o
);
    typedef struct packed {
        logic [2:0]                  mode;
        logic [N_MODES-1:0][DW-1:0]  rsr;
        logic [N_MODES-1:0][DW-1:0]  rar;
        logic [N_MODES-1:0][2:0]     prev;
        logic                        err;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.err = 1'b0;
        restore_o = 1'b0;
        if (enter_i) begin
            if (enter_mode_i != MODE_APP) begin
                ctx_d.rsr[enter_mode_i]  = sr_save_i;
                ctx_d.rar[enter_mode_i]  = enter_addr_i;
                ctx_d.prev[enter_mode_i] = ctx_q.mode;
            end
            ctx_d.mode = enter_mode_i;
        end else if (ret_i) begin
            if (mode_e'(ctx_q.mode) == MODE_APP) begin
                ctx_d.err = 1'b1;
            end else begin
                restore_o  = 1'b1;
                ctx_d.mode = ctx_q.prev[ctx_q.mode];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q      <= '0;
            ctx_q.mode <= MODE_SUP;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mode_o       = mode_e'(ctx_q.mode);
    assign ret_status_o = ctx_q.rsr[ctx_q.mode];
    assign ret_addr_o   = ctx_q.rar[ctx_q.mode];
    assign ret_err_o    = ctx_q.err;

    // R7
    entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && enter_mode_i != MODE_APP) |=>
            (mode_o == $past(enter_mode_i) && ret_addr_o == $past(enter_addr_i)));

    // R10
    app_ret_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !enter_i && mode_o == MODE_APP) |=> (ret_err_o && mode_o == MODE_APP));

    // R10
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_err_o) |-> $past(ret_i && mode_o == MODE_APP));

    // R12
    both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && ret_i) |=> (!ret_err_o && mode_o == $past(enter_mode_i)));

endmodule

// File: rtl/bregs_top.sv
module bregs_top
    import bregs_pkg::*;
#(
    parameter int                     DW          = 32,
    parameter logic [N_INT*N_SHD-1:0] SHADOW_MASK = 20'hFBC60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [DW-1:0]    rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [DW-1:0]    rd_b_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             enter_i,
    input  logic [2:0]       enter_mode_i,
    input  logic [DW-1:0]    enter_addr_i,
    input  logic             ret_i,
    output logic [2:0]       mode_o,
    output logic [DW-1:0]    ret_addr_o,
    output logic             ret_err_o
);
    localparam int N_PORTS = 3;

    typedef struct packed {
        logic [N_GEN-1:0][DW-1:0]             gen;
        logic [N_INT-1:0][N_SHD-1:0][DW-1:0]  shd;
        logic [DW-1:0]                        sp_app;
        logic [DW-1:0]                        sp_sys;
        logic [DW-1:0]                        lr_com;
        logic [N_INT-1:0][DW-1:0]             lr_int;
        logic [DW-1:0]                        pc;
        logic [DW-1:0]                        sr;
    } regs_t;

    regs_t st_d, st_q;

    mode_e         cur_mode;
    logic [DW-1:0] ret_status;
    logic          restore;
    logic [DW-1:0] sr_save;

    logic [N_PORTS-1:0][IDX_W-1:0] idx_arr;
    loc_t [N_PORTS-1:0]            loc_arr;

    assign idx_arr[0] = rd_a_idx;
    assign idx_arr[1] = rd_b_idx;
    assign idx_arr[2] = wr_idx;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_map
        bregs_map #(.SHADOW_MASK(SHADOW_MASK)) u_map (
            .mode_i (cur_mode),
            .idx_i  (idx_arr[p]),
            .loc_o  (loc_arr[p])
        );
    end

    function automatic logic [DW-1:0] pick(loc_t l, regs_t s);
        case (l.kind)
            LOC_GEN:   return s.gen[l.sel[3:0]];
            LOC_SHD:   return s.shd[l.sel[4:3]][l.sel[2:0]];
            LOC_SPAPP: return s.sp_app;
            LOC_SPSYS: return s.sp_sys;
            LOC_LRCOM: return s.lr_com;
            LOC_LRINT: return s.lr_int[l.sel[1:0]];
            LOC_PC:    return s.pc;
            LOC_SR:    return s.sr;
            default:   return '0;
        endcase
    endfunction

    assign rd_a_data = pick(loc_arr[0], st_q);
    assign rd_b_data = pick(loc_arr[1], st_q);
    assign sr_save   = (wr_en && loc_arr[2].kind == LOC_SR) ? wr_data : st_q.sr;

    bregs_ctx #(.DW(DW)) u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_i      (enter_i),
        .enter_mode_i (mode_e'(enter_mode_i)),
        .enter_addr_i (enter_addr_i),
        .ret_i        (ret_i),
        .sr_save_i    (sr_save),
        .mode_o       (cur_mode),
        .ret_status_o (ret_status),
        .ret_addr_o   (ret_addr_o),
        .restore_o    (restore),
        .ret_err_o    (ret_err_o)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (loc_arr[2].kind)
                LOC_GEN:   st_d.gen[loc_arr[2].sel[3:0]] = wr_data;
                LOC_SHD:   st_d.shd[loc_arr[2].sel[4:3]][loc_arr[2].sel[2:0]] = wr_data;
                LOC_SPAPP: st_d.sp_app = wr_data;
                LOC_SPSYS: st_d.sp_sys = wr_data;
                LOC_LRCOM: st_d.lr_com = wr_data;
                LOC_LRINT: st_d.lr_int[loc_arr[2].sel[1:0]] = wr_data;
                LOC_PC:    st_d.pc = wr_data;
                LOC_SR:    st_d.sr = wr_data;
                default:   ;
            endcase
        end
        if (restore) st_d.sr = ret_status;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o = cur_mode;

    // R9
    sr_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (st_q.sr == $past(ret_status)));

    // R8
    entry_sr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && enter_mode_i != 3'd0 && wr_en && int'(wr_idx) == IDX_SR) |=>
            (ret_status == $past(wr_data)));

    // R11
    pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) == IDX_PC) |=> (st_q.pc == $past(wr_data)));

endmodule

// File: tb/bregs_top_tb.sv
`timescale 1ns/1ps
module bregs_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, enter_addr_i, ret_addr_o;
    logic        wr_en, enter_i, ret_i, ret_err_o;
    logic [2:0]  enter_mode_i, mode_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bregs_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .enter_i(enter_i), .enter_mode_i(enter_mode_i), .enter_addr_i(enter_addr_i),
        .ret_i(ret_i), .mode_o(mode_o), .ret_addr_o(ret_addr_o), .ret_err_o(ret_err_o)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  widx;
        logic [31:0] wdata;
        logic [4:0]  ridx;
        logic [31:0] exp;
    } vec_t;

    // Supervisor mode; each row writes and reads in the same cycle (old value seen)
    localparam vec_t VEC [8] = '{
        '{1'b1, 5'd0,  32'h11,   5'd0,  32'h0},     // R11 read-before-write
        '{1'b1, 5'd13, 32'h5000, 5'd0,  32'h11},    // R2
        '{1'b1, 5'd14, 32'h700,  5'd13, 32'h5000},  // R3
        '{1'b1, 5'd15, 32'h100,  5'd14, 32'h700},   // R4
        '{1'b1, 5'd12, 32'hC,    5'd15, 32'h100},   // R6
        '{1'b1, 5'd16, 32'hABCD, 5'd12, 32'hC},     // R2
        '{1'b1, 5'd20, 32'hFFFF, 5'd16, 32'hABCD},  // R6
        '{1'b0, 5'd0,  32'h0,    5'd20, 32'h0}      // R6 out-of-range write ignored
    };

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_strobes();
        wr_en = 0; enter_i = 0; ret_i = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        idle_strobes();
        #1;
    endtask

    task automatic rd(string tag, int idx, logic [31:0] exp);
        rd_a_idx = 5'(idx); rd_b_idx = 5'(idx);
        #1;
        chk({tag, " portA"}, rd_a_data, exp);
        chk({tag, " portB"}, rd_b_data, exp);
    endtask

    task automatic wr(int idx, logic [31:0] d);
        wr_en = 1; wr_idx = 5'(idx); wr_data = d;
        tick();
    endtask

    task automatic enter(int m, logic [31:0] a);
        enter_i = 1; enter_mode_i = 3'(m); enter_addr_i = a;
        tick();
    endtask

    task automatic do_ret();
        ret_i = 1;
        tick();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_strobes();
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
        enter_mode_i = 0; enter_addr_i = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1; #1;

        // R1 reset state
        chk("R1 mode", 32'(mode_o), 32'd1);
        chk("R1 ret_addr", ret_addr_o, 32'h0);
        chk("R1 ret_err", 32'(ret_err_o), 32'h0);
        rd("R1 r0", 0, 0);
        rd("R1 sp", 13, 0);
        rd("R1 pc", 15, 0);
        rd("R1 sr", 16, 0);

        // table walk: R2 R3 R4 R6 R11
        for (int i = 0; i < 8; i++) begin
            wr_en = VEC[i].we; wr_idx = VEC[i].widx; wr_data = VEC[i].wdata;
            rd($sformatf("R11 table row %0d", i), int'(VEC[i].ridx), VEC[i].exp);
            tick();
        end

        // enter INT1
        enter(3, 32'h400);
        chk("R7 mode int1", 32'(mode_o), 32'd3);
        chk("R7 ret_addr int1", ret_addr_o, 32'h400);
        rd("R3 sys sp in int1", 13, 32'h5000);
        rd("R4 int1 lr bank", 14, 32'h0);
        rd("R5 r12 unshadowed int1", 12, 32'hC);
        rd("R2 r0 shared", 0, 32'h11);
        wr(8, 32'h88);
        wr(14, 32'h14);
        wr(16, 32'h1111);
        rd("R5 r8 shadow int1", 8, 32'h88);
        do_ret();
        chk("R9 mode back sup", 32'(mode_o), 32'd1);
        rd("R9 sr restored", 16, 32'hABCD);
        rd("R5 r8 sup copy", 8, 32'h0);
        rd("R4 common lr", 14, 32'h700);

        // R8: entry with same-cycle status write
        wr_en = 1; wr_idx = 16; wr_data = 32'h2222;
        enter(5, 32'h800);
        chk("R8 mode int3", 32'(mode_o), 32'd5);
        rd("R8 sr new", 16, 32'h2222);
        wr(16, 32'h3333);
        wr(12, 32'hC3);
        rd("R5 r12 shadow int3", 12, 32'hC3);
        do_ret();
        rd("R8 saved sr", 16, 32'h2222);
        rd("R5 r12 after int3", 12, 32'hC);

        // R7: entry into Application
        enter(0, 32'h999);
        chk("R7 mode app", 32'(mode_o), 32'd0);
        chk("R9 ret_addr app", ret_addr_o, 32'h0);
        rd("R3 app sp", 13, 32'h0);
        wr(13, 32'h9000);
        rd("R4 lr in app", 14, 32'h700);

        // R10: return in Application
        do_ret();
        chk("R10 err pulse", 32'(ret_err_o), 32'h1);
        chk("R10 mode stays", 32'(mode_o), 32'd0);
        rd("R10 sr kept", 16, 32'h2222);
        tick();
        chk("R10 err one cycle", 32'(ret_err_o), 32'h0);

        // R12: entry and return together
        enter_i = 1; enter_mode_i = 3'd4; enter_addr_i = 32'hA00; ret_i = 1;
        tick();
        chk("R12 mode int2", 32'(mode_o), 32'd4);
        chk("R12 no err", 32'(ret_err_o), 32'h0);
        chk("R12 ret_addr", ret_addr_o, 32'hA00);
        wr(11, 32'hB11);
        wr(14, 32'h2A);
        rd("R3 sys sp int2", 13, 32'h5000);
        do_ret();
        chk("R9 back to app", 32'(mode_o), 32'd0);
        rd("R5 r11 app copy", 11, 32'h0);
        rd("R4 lr app after int2", 14, 32'h700);
        rd("R3 app sp kept", 13, 32'h9000);

        // nested Exception -> NMI
        enter(6, 32'hE00);
        rd("R3 sys sp exc", 13, 32'h5000);
        enter(7, 32'hF00);
        chk("R7 nmi ret_addr", ret_addr_o, 32'hF00);
        do_ret();
        chk("R9 nested mode", 32'(mode_o), 32'd6);
        chk("R9 nested ret_addr", ret_addr_o, 32'hE00);
        do_ret();
        chk("R9 unwind app", 32'(mode_o), 32'd0);

        // R11: PC same-cycle read/write
        wr_en = 1; wr_idx = 15; wr_data = 32'h200;
        rd("R11 pc old", 15, 32'h100);
        tick();
        rd("R11 pc new", 15, 32'h200);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule